// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software with a counter that runs from a slow, free-running clock kept apart from the processor clock. Once software sets the run enable, the block captures the timeout length, the size of the refresh window and the early-interrupt enable. From then on these settings stay fixed until the next reset. Each interval lasts a power-of-two number of slow-clock cycles. Software must refresh the counter while the window is open, and the window always sits at the end of the interval. A refresh that comes too early is a fault. An interval that expires with no refresh is also a fault. Either fault produces a reset request pulse of fixed length.

An optional early-warning interrupt fires three quarters of the way through the interval. The window is open at that point for every window size, so an interrupt handler can refresh safely when it sees the interrupt. A valid refresh restarts the interval from zero, and the warning then fires again in the new interval.

Top module: `winwdt_top`

## Requirements
- R1: After reset, `rst_req` and `early_irq` are low and the counter stays idle while `cfg_run` is low; refresh strobes in that state have no effect.
- R2: The interval length is T = 2^(BASE_LOG2 + `cfg_tcode`) cycles. With no refresh, `rst_req` rises on the T-th rising edge after the edge that sampled `cfg_run` high.
- R3: A refresh sampled while the window is closed raises `rst_req` on the next edge.
- R4: The window encoding on `cfg_wsel` is as follows. 2'b00 opens the window at count T/2. 2'b01 opens it at count T/4. 2'b10 and 2'b11 keep it open for the whole interval. A refresh at any count from the opening point up to T-1 is accepted without a reset request.
- R5: The count never passes T-1. After a reset request it restarts from zero, so a second timeout follows T cycles after the first.
- R6: A valid refresh clears the count to zero. This includes a refresh at count T-1. The next timeout then comes T cycles later, and the early interrupt fires again in the new interval.
- R7: When enabled, `early_irq` is high for exactly the one cycle in which the count equals 3T/4. When disabled, it never rises.
- R8: The settings are captured on the edge where `cfg_run` is first seen high. Later changes to `cfg_tcode`, `cfg_wsel`, `cfg_irq_en` and `cfg_run` are ignored until reset.
- R9: Each reset request is a registered pulse that stays high for exactly RST_CYCLES cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-speed watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tcode | input | 3 | Interval length code, T = 2^(BASE_LOG2+code) |
| cfg_wsel | input | 2 | Window size select |
| cfg_irq_en | input | 1 | Early-warning interrupt enable |
| cfg_run | input | 1 | Start request; captures the settings |
| refresh | input | 1 | Refresh strobe, one cycle per refresh |
| early_irq | output | 1 | Early-warning interrupt at 3T/4 |
| rst_req | output | 1 | Reset request pulse |

## Verification
Assertions check several rules on every cycle. The captured settings stay stable while the block runs. The count stays below its limit. The early interrupt only fires inside the open window. Every early refresh and every timeout is followed by a reset request. A valid refresh clears the count. The pulse counter stays within its length. Only the bench's scenarios show the exact cycle counts. It sweeps every interval code against every window size and measures the timeout edge, the interrupt position, the acceptance boundary on both sides of the opening point, and the pulse width. It also shows that changes to the settings after start are ignored and that a refresh at the last count is still accepted.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;

  typedef struct packed {
    logic [2:0] tcode;
    logic [1:0] wsel;
    logic       irq_en;
  } wdt_cfg_t;

  // log2 of the interval length for a given code
  function automatic int unsigned span_log2(int unsigned base, logic [2:0] code);
    return base + int'(code);
  endfunction

  // last legal count value, T-1
  function automatic int unsigned last_count(int unsigned base, logic [2:0] code);
    return (32'd1 << span_log2(base, code)) - 32'd1;
  endfunction

  // first count at which a refresh is accepted
  function automatic int unsigned open_point(int unsigned base, logic [2:0] code,
                                             logic [1:0] wsel);
    int unsigned l;
    l = span_log2(base, code);
    case (wsel)
      2'b00:   return 32'd1 << (l - 1);
      2'b01:   return 32'd1 << (l - 2);
      default: return 32'd0;
    endcase
  endfunction

  // early-warning point, three quarters of the interval
  function automatic int unsigned warn_point(int unsigned base, logic [2:0] code);
    return 32'd3 << (span_log2(base, code) - 2);
  endfunction

endpackage

// File: rtl/wwdt_cfg_latch.sv
module wwdt_cfg_latch
  import wwdt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  wdt_cfg_t cfg_in,
  input  logic     run_req,
  output wdt_cfg_t cfg_q,
  output logic     running
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      running <= 1'b0;
    end else if (!running && run_req) begin
      cfg_q   <= cfg_in;
      running <= 1'b1;
    end
  end

  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running)) |-> $stable(cfg_q));

  assert_run_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(running) |-> running);

endmodule

// File: rtl/wwdt_counter.sv
module wwdt_counter
  import wwdt_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 4,
  parameter int unsigned CNT_W     = BASE_LOG2 + 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             running,
  input  wdt_cfg_t         cfg,
  input  logic             refresh,
  output logic [CNT_W-1:0] cnt,
  output logic             win_open,
  output logic             warn_hit,
  output logic             timeout,
  output logic             bad_refresh
);

  logic [CNT_W-1:0] last_c;
  logic [CNT_W-1:0] open_c;
  logic [CNT_W-1:0] warn_c;

  always_comb begin
    last_c      = CNT_W'(last_count(BASE_LOG2, cfg.tcode));
    open_c      = CNT_W'(open_point(BASE_LOG2, cfg.tcode, cfg.wsel));
    warn_c      = CNT_W'(warn_point(BASE_LOG2, cfg.tcode));
    win_open    = (cnt >= open_c);
    warn_hit    = running && (cnt == warn_c);
    timeout     = running && !refresh && (cnt == last_c);
    bad_refresh = running && refresh && !win_open;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!running || refresh || timeout) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt <= last_c));

  assert_warn_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    warn_hit |-> win_open);

  assert_refresh_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && refresh && win_open) |=> (cnt == '0));

  assert_idle_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (cnt == '0));

endmodule

// File: rtl/wwdt_rst_pulse.sv
module wwdt_rst_pulse #(
  parameter int unsigned RST_CYCLES = 4,
  localparam int unsigned PW        = $clog2(RST_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  output logic rst_req
);

  logic [PW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left    <= '0;
      rst_req <= 1'b0;
    end else if (trigger) begin
      left    <= PW'(RST_CYCLES);
      rst_req <= 1'b1;
    end else if (left != '0) begin
      left    <= left - 1'b1;
      rst_req <= (left > PW'(1));
    end
  end

  assert_pulse_loaded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> (rst_req && left == PW'(RST_CYCLES)));

  assert_pulse_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    left <= PW'(RST_CYCLES));

endmodule

// File: rtl/winwdt_top.sv
module winwdt_top
  import wwdt_pkg::*;
#(
  parameter int unsigned BASE_LOG2  = 4,
  parameter int unsigned RST_CYCLES = 4,
  localparam int unsigned CNT_W     = BASE_LOG2 + 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cfg_tcode,
  input  logic [1:0] cfg_wsel,
  input  logic       cfg_irq_en,
  input  logic       cfg_run,
  input  logic       refresh,
  output logic       early_irq,
  output logic       rst_req
);

  wdt_cfg_t         cfg_in;
  wdt_cfg_t         cfg_q;
  logic             running;
  logic [CNT_W-1:0] cnt;
  logic             win_open;
  logic             warn_hit;
  logic             timeout;
  logic             bad_refresh;
  logic             fault;

  assign cfg_in = '{tcode: cfg_tcode, wsel: cfg_wsel, irq_en: cfg_irq_en};

  wwdt_cfg_latch u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_in  (cfg_in),
    .run_req (cfg_run),
    .cfg_q   (cfg_q),
    .running (running)
  );

  wwdt_counter #(.BASE_LOG2(BASE_LOG2), .CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .running     (running),
    .cfg         (cfg_q),
    .refresh     (refresh),
    .cnt         (cnt),
    .win_open    (win_open),
    .warn_hit    (warn_hit),
    .timeout     (timeout),
    .bad_refresh (bad_refresh)
  );

  assign fault     = timeout || bad_refresh;
  assign early_irq = warn_hit && cfg_q.irq_en;

  wwdt_rst_pulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .trigger (fault),
    .rst_req (rst_req)
  );

  assert_early_refresh_resets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bad_refresh |=> rst_req);

  assert_timeout_resets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> rst_req);

  assert_irq_single_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    early_irq |=> !early_irq);

  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.irq_en |-> !early_irq);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !$past(running)) |-> !rst_req);

endmodule

// File: tb/winwdt_top_tb.sv
module winwdt_top_tb;

  localparam int BASE = 4;
  localparam int PUL  = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cfg_tcode = '0;
  logic [1:0] cfg_wsel = '0;
  logic       cfg_irq_en = 1'b0;
  logic       cfg_run = 1'b0;
  logic       refresh = 1'b0;
  logic       early_irq;
  logic       rst_req;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  winwdt_top #(.BASE_LOG2(BASE), .RST_CYCLES(PUL)) u_dut (
    .clk (clk), .rst_n (rst_n), .cfg_tcode (cfg_tcode), .cfg_wsel (cfg_wsel),
    .cfg_irq_en (cfg_irq_en), .cfg_run (cfg_run), .refresh (refresh),
    .early_irq (early_irq), .rst_req (rst_req)
  );

  function automatic int span(int code);
    return 16 * (1 << code) / 16 * (1 << BASE) / 16 * 1;
  endfunction

  function automatic int first_ok(int t, int sel);
    if (sel == 0) return t / 2;
    if (sel == 1) return t - (t * 3) / 4;
    return 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic advance(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cfg_run = 1'b0; refresh = 1'b0;
    advance(2);
    rst_n = 1'b1;
    tick();
  endtask

  task automatic start(input int code, input int sel, input bit en);
    cfg_tcode = 3'(code); cfg_wsel = 2'(sel); cfg_irq_en = en; cfg_run = 1'b1;
    tick();
  endtask

  task automatic pulse_refresh();
    refresh = 1'b1;
    tick();
    refresh = 1'b0;
  endtask

  // from count 0: walk the interval, then verify the timeout pulse
  task automatic scan(input int t, input bit en, input string req);
    int bad_c = -1;
    int bad_irq = 0;
    for (int c = 0; c < t; c++) begin
      if (rst_req !== 1'b0 || early_irq !== (en && c == (t * 3) / 4)) begin
        if (bad_c < 0) begin bad_c = c; bad_irq = int'(early_irq); end
      end
      tick();
    end
    check(bad_c < 0, {req, " R7 irq/quiet in interval at count"}, bad_c, -1);
    check(rst_req === 1'b1, {req, " R2 timeout edge"}, int'(rst_req), 1);
    for (int i = 1; i < PUL; i++) begin
      tick();
      check(rst_req === 1'b1, {req, " R9 pulse held"}, int'(rst_req), 1);
    end
    tick();
    check(rst_req === 1'b0, {req, " R9 pulse end"}, int'(rst_req), 0);
    if (bad_irq < 0) $display("unreachable");
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired R2 actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state and idle behaviour
    check(rst_req === 1'b0 && early_irq === 1'b0, "R1 reset outputs", int'(rst_req), 0);
    for (int i = 0; i < 40; i++) begin
      refresh = (i % 3 == 0);
      tick();
      if (rst_req !== 1'b0 || early_irq !== 1'b0)
        check(1'b0, "R1 idle quiet", int'(rst_req), 0);
    end
    refresh = 1'b0;
    check(rst_req === 1'b0, "R1 idle after refreshes", int'(rst_req), 0);

    for (int code = 0; code < 8; code++) begin
      for (int sel = 0; sel < 3; sel++) begin
        int  t;
        int  op;
        bit  en;
        t  = (1 << (BASE + code));
        op = first_ok(t, sel);
        en = ((code + sel) % 2) == 0;

        // timeout, then R5 restart from zero gives a second timeout T later
        do_reset();
        start(code, sel, en);
        scan(t, en, "A");
        advance(t - 1 - PUL);
        check(rst_req === 1'b0, "R5 before second timeout", int'(rst_req), 0);
        tick();
        check(rst_req === 1'b1, "R5 second timeout", int'(rst_req), 1);

        // R3: refresh one count before the window opens
        if (op > 0) begin
          do_reset();
          start(code, sel, en);
          advance(op - 1);
          pulse_refresh();
          check(rst_req === 1'b1, "R3 early refresh resets", int'(rst_req), 1);
        end

        // R4: refresh at the opening point; R6: at the last count, then rearm
        do_reset();
        start(code, sel, en);
        advance(op);
        pulse_refresh();
        check(rst_req === 1'b0, "R4 refresh at opening accepted", int'(rst_req), 0);
        advance(t - 1);
        pulse_refresh();
        check(rst_req === 1'b0, "R6 refresh at last count accepted", int'(rst_req), 0);
        scan(t, en, "R6 rearm");

        // R8: settings changed after start are ignored
        do_reset();
        start(code, sel, en);
        cfg_tcode  = 3'(code ^ 3);
        cfg_wsel   = 2'((sel + 1) % 3);
        cfg_irq_en = ~en;
        cfg_run    = 1'b0;
        scan(t, en, "R8 locked");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule